// File: doc/BRIEF.md
# Dual-Output Masked Interrupt Controller

The block gathers a vector of level-sensitive interrupt sources and presents two request lines to a processor: a normal request and a fast request. Each request line has its own enable mask, so any source can be routed to either line, to both or to neither. A line is raised whenever at least one active source is enabled in that line's mask. The block does not prioritise, vector or latch edges; the sources are expected to hold their level until serviced.

Software reaches the block through a word-addressed register port with one-cycle synchronous writes and reads. A mask is never written whole: one address ORs ones into it and a second address removes the written ones, so two drivers can change different bits without a read-modify-write. Source 0 carries an extra software latch, which software can raise and lower to post an interrupt to itself; the effective level of source 0 is the OR of its hardware input and that latch. Status words show the active sources, the active-and-enabled sources per line, and both masks.

Top module: `irq_fiq_ctrl`

## Requirements
- R1: One clock after the effective level vector ANDed with the normal mask becomes nonzero, `irq` is 1; one clock after that AND becomes zero, `irq` is 0.
- R2: `fiq` follows the effective level ANDed with the fast mask with the same one-clock delay.
- R3: A write to word 2 ORs `wdata` into the normal mask, a write to word 3 clears the mask bits that are 1 in `wdata`, and a read of word 2 returns the normal mask.
- R4: A write to word 10 ORs `wdata` into the fast mask, a write to word 11 clears the mask bits that are 1 in `wdata`, and a read of word 10 returns the fast mask.
- R5: A read of word 0 returns the effective level AND the normal mask; a read of word 8 returns the effective level AND the fast mask.
- R6: Reads of word 1 and word 9 both return the effective level vector.
- R7: A write to word 4 with `wdata` bit 0 set raises the source-0 software latch; a write to word 5 with bit 0 set lowers it; with bit 0 clear either write has no effect. Effective level bit 0 is `src_lvl[0]` OR the latch; other bits equal `src_lvl`.
- R8: A read of word 4 returns effective level bit 0 in bit 0 and zero in all other bits.
- R9: Reads of words 3, 5 and 11 and of every word other than 0, 1, 2, 4, 8, 9 and 10 return zero.
- R10: Writes to words 0, 1, 8, 9 and to every word other than 2, 3, 4, 5, 10 and 11 change neither mask nor the software latch.
- R11: After reset both masks and the software latch are zero and `irq`, `fiq` and `rdata` are 0.
- R12: `rdata` takes the addressed word on the clock edge at which `rd_en` is 1 and holds its value on every edge at which `rd_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_lvl | input | NUM_SRC | Source level vector, 1 = active |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Normal interrupt request, registered |
| fiq | output | 1 | Fast interrupt request, registered |

## Verification
The bench builds the block with its defaults: 32 sources, a 32-bit data word and a 6-bit word address. With only 64 addresses it reads every one of them after each change of state and writes all unmapped and status addresses with all-ones, so every decode hole and every ignored write is observed. Thirty-two sources let walking-one patterns cover each mask bit on both lines, while a pseudo-random series of source levels, set and clear values and soft-latch operations exercises the two masks and source 0 together.

// File: rtl/irq_fiq_pkg.sv
package irq_fiq_pkg;

   localparam int unsigned NUM_CH = 2;
   localparam int unsigned CH_NRM = 0;
   localparam int unsigned CH_FST = 1;

   localparam int unsigned OFS_NRM_STAT = 0;
   localparam int unsigned OFS_NRM_RAW  = 1;
   localparam int unsigned OFS_NRM_SET  = 2;
   localparam int unsigned OFS_NRM_CLR  = 3;
   localparam int unsigned OFS_SW_SET   = 4;
   localparam int unsigned OFS_SW_CLR   = 5;
   localparam int unsigned OFS_FST_STAT = 8;
   localparam int unsigned OFS_FST_RAW  = 9;
   localparam int unsigned OFS_FST_SET  = 10;
   localparam int unsigned OFS_FST_CLR  = 11;

   localparam int unsigned MIN_ADDR_W = 4;

   function automatic int unsigned set_ofs(input int unsigned ch);
      return (ch == CH_NRM) ? OFS_NRM_SET : OFS_FST_SET;
   endfunction

   function automatic int unsigned clr_ofs(input int unsigned ch);
      return (ch == CH_NRM) ? OFS_NRM_CLR : OFS_FST_CLR;
   endfunction

endpackage

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
   parameter int unsigned WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_stb,
   input  logic             clr_stb,
   input  logic [WIDTH-1:0] bits,
   output logic [WIDTH-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (set_stb) begin
         q <= q | bits;
      end else if (clr_stb) begin
         q <= q & ~bits;
      end
   end

   AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
      set_stb |=> ((q & $past(bits)) == $past(bits))); // R3, R4
   AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_stb && !set_stb) |=> ((q & $past(bits)) == '0)); // R3, R4
   AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_stb && !clr_stb) |=> $stable(q)); // R10

endmodule

// File: rtl/irq_src_merge.sv
module irq_src_merge #(
   parameter int unsigned NUM_SRC = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sw_raise,
   input  logic               sw_lower,
   input  logic [NUM_SRC-1:0] src_lvl,
   output logic [NUM_SRC-1:0] eff_lvl
);

   logic sw_latch;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sw_latch <= 1'b0;
      end else if (sw_raise) begin
         sw_latch <= 1'b1;
      end else if (sw_lower) begin
         sw_latch <= 1'b0;
      end
   end

   assign eff_lvl = src_lvl | NUM_SRC'(sw_latch);

   AST_SW_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
      sw_raise |=> eff_lvl[0]); // R7
   AST_SW_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_lower && !sw_raise) |=> (eff_lvl[0] == src_lvl[0])); // R7

endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
   import irq_fiq_pkg::*;
#(
   parameter int unsigned NUM_SRC = 32,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rd_en,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [NUM_SRC-1:0] eff_lvl,
   input  logic [NUM_SRC-1:0] nrm_mask,
   input  logic [NUM_SRC-1:0] fst_mask,
   output logic [DATA_W-1:0]  rdata
);

   logic [DATA_W-1:0] sel_word;
   logic              mapped;

   always_comb begin
      sel_word = '0;
      mapped   = 1'b1;
      case (addr)
         ADDR_W'(OFS_NRM_STAT): sel_word = DATA_W'(eff_lvl & nrm_mask);
         ADDR_W'(OFS_NRM_RAW):  sel_word = DATA_W'(eff_lvl);
         ADDR_W'(OFS_NRM_SET):  sel_word = DATA_W'(nrm_mask);
         ADDR_W'(OFS_SW_SET):   sel_word = DATA_W'(eff_lvl[0]);
         ADDR_W'(OFS_FST_STAT): sel_word = DATA_W'(eff_lvl & fst_mask);
         ADDR_W'(OFS_FST_RAW):  sel_word = DATA_W'(eff_lvl);
         ADDR_W'(OFS_FST_SET):  sel_word = DATA_W'(fst_mask);
         default:               mapped   = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
      end else if (rd_en) begin
         rdata <= sel_word;
      end
   end

   AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata)); // R12
   AST_RD_HOLE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !mapped) |=> (rdata == '0)); // R9
   AST_RD_SOFT: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == ADDR_W'(OFS_SW_SET)) |=> (rdata[DATA_W-1:1] == '0)); // R8

endmodule

// File: rtl/irq_fiq_ctrl.sv
module irq_fiq_ctrl
   import irq_fiq_pkg::*;
#(
   parameter int unsigned NUM_SRC = 32,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_lvl,
   input  logic               wr_en,
   input  logic               rd_en,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [DATA_W-1:0]  wdata,
   output logic [DATA_W-1:0]  rdata,
   output logic               irq,
   output logic               fiq
);

   generate
      if (NUM_SRC < 1 || NUM_SRC > DATA_W) begin : g_bad_src
         $error("NUM_SRC must lie in 1..DATA_W");
      end
      if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr
         $error("ADDR_W too narrow for the register map");
      end
   endgenerate

   logic [NUM_SRC-1:0] eff_lvl;
   logic [NUM_SRC-1:0] mask_q [NUM_CH];
   logic [NUM_CH-1:0]  req_q;
   logic               sw_raise;
   logic               sw_lower;

   assign sw_raise = wr_en && (addr == ADDR_W'(OFS_SW_SET)) && wdata[0];
   assign sw_lower = wr_en && (addr == ADDR_W'(OFS_SW_CLR)) && wdata[0];

   irq_src_merge #(.NUM_SRC(NUM_SRC)) u_merge (
      .clk      (clk),
      .rst_n    (rst_n),
      .sw_raise (sw_raise),
      .sw_lower (sw_lower),
      .src_lvl  (src_lvl),
      .eff_lvl  (eff_lvl)
   );

   generate
      for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
         logic set_stb;
         logic clr_stb;

         assign set_stb = wr_en && (addr == ADDR_W'(set_ofs(ch)));
         assign clr_stb = wr_en && (addr == ADDR_W'(clr_ofs(ch)));

         irq_mask_reg #(.WIDTH(NUM_SRC)) u_mask (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_stb (set_stb),
            .clr_stb (clr_stb),
            .bits    (wdata[NUM_SRC-1:0]),
            .q       (mask_q[ch])
         );

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               req_q[ch] <= 1'b0;
            end else begin
               req_q[ch] <= |(eff_lvl & mask_q[ch]);
            end
         end
      end
   endgenerate

   assign irq = req_q[CH_NRM];
   assign fiq = req_q[CH_FST];

   irq_read_mux #(
      .NUM_SRC (NUM_SRC),
      .DATA_W  (DATA_W),
      .ADDR_W  (ADDR_W)
   ) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_en    (rd_en),
      .addr     (addr),
      .eff_lvl  (eff_lvl),
      .nrm_mask (mask_q[CH_NRM]),
      .fst_mask (mask_q[CH_FST]),
      .rdata    (rdata)
   );

   AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q[CH_NRM] == '0) |=> !irq); // R1
   AST_FIQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q[CH_FST] == '0) |=> !fiq); // R2
   AST_IRQ_SRC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (eff_lvl == '0) |=> (!irq && !fiq)); // R1, R2

endmodule

// File: tb/test_irq_fiq_ctrl.sv
module test_irq_fiq_ctrl;

   localparam int unsigned NS = 32;
   localparam int unsigned DW = 32;
   localparam int unsigned AW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] src_lvl = '0;
   logic          wr_en = 1'b0;
   logic          rd_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          irq;
   logic          fiq;

   int total = 0;
   int bad   = 0;

   logic [NS-1:0] m_nrm = '0;
   logic [NS-1:0] m_fst = '0;
   logic          m_sw  = 1'b0;
   logic [31:0]   seed  = 32'h1234_5678;

   always #10 clk = ~clk;

   irq_fiq_ctrl #(.NUM_SRC(NS), .DATA_W(DW), .ADDR_W(AW)) i_irq_fiq_ctrl (
      .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .fiq(fiq)
   );

   function automatic logic [NS-1:0] lvl_of();
      return src_lvl | NS'(m_sw);
   endfunction

   function automatic logic [DW-1:0] exp_word(input int a);
      logic [NS-1:0] l;
      l = lvl_of();
      if (a == 0) return DW'(l & m_nrm);
      if (a == 1 || a == 9) return DW'(l);
      if (a == 2) return DW'(m_nrm);
      if (a == 4) return DW'(l[0]);
      if (a == 8) return DW'(l & m_fst);
      if (a == 10) return DW'(m_fst);
      return '0;
   endfunction

   task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic nxt();
      seed = seed * 32'd1664525 + 32'd1013904223;
   endtask

   task automatic wr(input int a, input logic [DW-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = AW'(a); wdata = d;
      @(negedge clk);
      wr_en = 1'b0; wdata = '0;
      if (a == 2) m_nrm = m_nrm | d[NS-1:0];
      if (a == 3) m_nrm = m_nrm & ~d[NS-1:0];
      if (a == 10) m_fst = m_fst | d[NS-1:0];
      if (a == 11) m_fst = m_fst & ~d[NS-1:0];
      if (a == 4 && d[0]) m_sw = 1'b1;
      if (a == 5 && d[0]) m_sw = 1'b0;
   endtask

   task automatic rd(input int a, output logic [DW-1:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = AW'(a);
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata;
   endtask

   task automatic chk_rd(input string tag, input int a);
      logic [DW-1:0] d;
      logic [DW-1:0] e;
      e = exp_word(a);
      rd(a, d);
      chk(tag, d, e);
   endtask

   task automatic chk_out(input string tag);
      chk({tag, " R1 irq"}, DW'(irq), DW'(|(lvl_of() & m_nrm)));
      chk({tag, " R2 fiq"}, DW'(fiq), DW'(|(lvl_of() & m_fst)));
   endtask

   task automatic sweep(input string tag);
      for (int a = 0; a < (1 << AW); a++) begin
         if (a == 0 || a == 8) chk_rd({tag, " R5 status"}, a);
         else if (a == 1 || a == 9) chk_rd({tag, " R6 raw"}, a);
         else if (a == 2) chk_rd({tag, " R3 nrm mask"}, a);
         else if (a == 10) chk_rd({tag, " R4 fst mask"}, a);
         else if (a == 4) chk_rd({tag, " R8 soft read"}, a);
         else chk_rd({tag, " R9 hole"}, a);
      end
      chk_out(tag);
   endtask

   initial begin
      #(20 * 200000);
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [DW-1:0] d;
      logic [DW-1:0] held;
      #25;
      chk("R11 irq after reset", DW'(irq), '0);
      chk("R11 fiq after reset", DW'(fiq), '0);
      chk("R11 rdata after reset", rdata, '0);
      @(negedge clk);
      rst_n = 1'b1;
      chk_rd("R11 nrm mask reset", 2);
      chk_rd("R11 fst mask reset", 10);
      chk_rd("R11 soft latch reset", 4);
      sweep("reset state");

      // Walking-one mask set and clear on both lines
      src_lvl = '1;
      for (int i = 0; i < NS; i++) begin
         wr(2, DW'(1) << i);
         chk_rd("R3 set walk", 2);
         wr(10, DW'(1) << (NS - 1 - i));
         chk_rd("R4 set walk", 10);
      end
      chk_out("all set");
      for (int i = 0; i < NS; i++) begin
         wr(3, DW'(1) << i);
         chk_rd("R3 clr walk", 2);
         chk_out("clr walk");
      end
      for (int i = 0; i < NS; i++) begin
         wr(11, DW'(1) << i);
         chk_rd("R4 clr walk", 10);
      end
      chk_out("all clear");

      // Output timing: one clock from level change to request
      wr(2, 32'h0000_0100);
      wr(10, 32'h0001_0000);
      src_lvl = '0;
      @(negedge clk);
      chk_out("levels low");
      @(negedge clk);
      src_lvl = 32'h0000_0100;
      #1;
      chk("R1 irq not yet", DW'(irq), '0);
      @(negedge clk);
      chk("R1 irq one clock later", DW'(irq), DW'(1));
      chk("R2 fiq unaffected", DW'(fiq), '0);
      src_lvl = 32'h0001_0000;
      #1;
      chk("R1 irq still old", DW'(irq), DW'(1));
      @(negedge clk);
      chk("R1 irq fell", DW'(irq), '0);
      chk("R2 fiq rose", DW'(fiq), DW'(1));
      src_lvl = '0;
      @(negedge clk);
      chk("R2 fiq fell", DW'(fiq), '0);

      // Mask write timing: request follows mask one clock after the write edge
      src_lvl = 32'h8000_0000;
      wr(2, 32'h8000_0000);
      chk("R1 irq not yet after mask write", DW'(irq), '0);
      @(negedge clk);
      chk("R1 irq after mask write", DW'(irq), DW'(1));
      wr(3, 32'h8000_0000);
      @(negedge clk);
      chk("R3 irq after mask clear", DW'(irq), '0);

      // Software latch on source 0
      src_lvl = '0;
      wr(2, 32'h0000_0001);
      wr(4, 32'hFFFF_FFFE);
      chk_rd("R7 soft set bit0 clear ignored", 1);
      wr(4, 32'h0000_0001);
      chk_rd("R7 soft set raw", 1);
      chk_rd("R8 soft read high", 4);
      @(negedge clk);
      chk_out("R7 soft raised");
      wr(5, 32'hFFFF_FFFE);
      chk_rd("R7 soft clr bit0 clear ignored", 4);
      wr(5, 32'h0000_0001);
      chk_rd("R7 soft lowered", 1);
      @(negedge clk);
      chk_out("R7 soft lowered");
      src_lvl = 32'h0000_0001;
      chk_rd("R7 hw source 0 alone", 4);
      wr(4, 32'h1);
      src_lvl = '0;
      chk_rd("R7 latch alone keeps level", 1);
      wr(5, 32'h1);

      // Ignored writes: status words and holes
      wr(2, 32'h0F0F_1234);
      wr(10, 32'hA000_00FF);
      for (int a = 0; a < (1 << AW); a++) begin
         if (!(a == 2 || a == 3 || a == 4 || a == 5 || a == 10 || a == 11)) begin
            wr(a, '1);
         end
      end
      chk_rd("R10 nrm mask untouched", 2);
      chk_rd("R10 fst mask untouched", 10);
      chk_rd("R10 soft latch untouched", 4);
      sweep("after ignored writes");

      // Read hold
      src_lvl = 32'h5555_AAAA;
      rd(1, held);
      src_lvl = 32'h0;
      wr(2, '1);
      repeat (3) @(negedge clk);
      chk("R12 rdata held", rdata, held);
      chk("R12 rdata captured", held, 32'h5555_AAAA);

      // Pseudo-random mixed states with full address sweeps
      for (int k = 0; k < 16; k++) begin
         nxt(); src_lvl = seed;
         nxt(); wr(2, seed);
         nxt(); wr(3, seed);
         nxt(); wr(10, seed);
         nxt(); wr(11, seed ^ 32'hFFFF_0000);
         nxt(); wr((seed[3]) ? 4 : 5, {31'd0, seed[7]});
         @(negedge clk);
         sweep("mixed");
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule